// File: doc/BRIEF.md
# USB Endpoint Dual-Bank Status Controller

This block keeps the status and interrupt flags of one USB device endpoint, together with the ping-pong bookkeeping of its two data banks. A packet engine reports what happened on the bus: a data packet or a SETUP packet stored, an IN bank transmitted, a NAK answered to an IN or to an OUT/PING request, a STALL returned. The firmware moves bytes into or out of the current bank, and those moves are reported as push and pop strobes. Only the byte count of each bank is tracked. The data storage itself is outside the block.

Software sees one 8-bit status register. It writes that register with a per-bit strobe, and the only useful write is a 0, which acknowledges a flag. Writing 0 to the bank-control bit hands the current bank over and moves to the other bank. On an OUT endpoint this releases a bank that has been read. On an IN endpoint it commits a bank that has been filled. A separate kill request discards the most recently committed IN bank and clears itself once done. The interrupt line is the OR of the enabled flags.

Top module: `ep_bank_status`

## Requirements
- R1: After reset all flags read 0 and the current bank is 0. On an OUT endpoint the register reads 0x00. On an IN endpoint both banks are free, so it reads 0xA0.
- R2: The register reads, from bit 7 down to bit 0: bank control, NAK-IN, read/write-allowed, NAK-OUT, SETUP-received, OUT-received, STALL, IN-ready. Every change appears on the cycle after the event that causes it.
- R3: On an OUT endpoint a stored packet fills the bank the engine points at, and its length is clamped to BANK_BYTES. The packet sets OUT-received (bit 2). Bank control reads 1 whenever the current bank holds a packet, so it rises in the same cycle when the packet lands in the current bank. Read/write-allowed is high while that packet has bytes left, and each pop removes one byte.
- R4: On an OUT endpoint, writing 0 to bit 7 frees the current bank and switches to the other bank. Writing 1 to bit 7 does nothing. A packet that arrives while both banks are held is dropped and sets no flag.
- R5: On an IN endpoint each push adds one byte to the current bank. Read/write-allowed stays high while the count is below BANK_BYTES. Writing 0 to bit 7 commits the bank and switches banks. An IN-sent report frees the oldest committed bank and sets IN-ready (bit 0). IN-sent has no effect on an OUT endpoint.
- R6: A SETUP report sets SETUP-received (bit 3) and bank control like a packet does. It takes precedence over a packet report in the same cycle. On an IN endpoint SETUP reports are ignored and bit 3 is held at 0.
- R7: The NAK-IN, NAK-OUT and STALL reports set bits 6, 4 and 1. No software write ever sets a flag.
- R8: A strobed write of 0 clears a flag on the next cycle. A write of 1, or an unstrobed bit, leaves the flag as it is. A hardware set in the same cycle as a clear wins.
- R9: irq is the OR of flag bits 6, 4, 3, 2, 1 and 0, each ANDed with the matching irq_en bit. irq_en bits 7 and 5 have no effect.
- R10: Read/write-allowed is forced low while stall_req, err_flag or cfg_ctrl_ep is high. Pushes and pops made then are ignored.
- R11: Writing kill_wdata=1 sets kill_busy. Writing 0 is ignored. The kill waits out any cycle with an IN-sent report or a commit. It then frees the most recently committed IN bank with its count reset to 0, and clears kill_busy. With no committed bank, or on an OUT endpoint, it only clears kill_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ctrl_ep | input | 1 | Endpoint is the control endpoint |
| stall_req | input | 1 | Stall request active |
| err_flag | input | 1 | Error condition present |
| pe_pkt_rx | input | 1 | Data packet stored |
| pe_setup_rx | input | 1 | SETUP packet stored |
| pe_rx_len | input | CNT_W | Byte length of the stored packet |
| pe_in_sent | input | 1 | IN bank transmitted |
| pe_nak_in | input | 1 | NAK answered to an IN request |
| pe_nak_out | input | 1 | NAK answered to an OUT/PING request |
| pe_stall_sent | input | 1 | STALL handshake returned |
| fifo_push | input | 1 | One byte written into the current IN bank |
| fifo_pop | input | 1 | One byte read from the current OUT bank |
| reg_wr | input | 1 | Register write |
| reg_wmask | input | 8 | Per-bit write strobes |
| reg_wdata | input | 8 | Write data |
| irq_en | input | 8 | Interrupt enables, aligned with the flag bits |
| kill_wr | input | 1 | Write to the kill request bit |
| kill_wdata | input | 1 | Kill request write value |
| reg_rdata | output | 8 | Status register |
| cur_bank | output | 1 | Index of the current bank |
| rw_allowed | output | 1 | Firmware may push or pop |
| kill_busy | output | 1 | Kill request pending |
| irq | output | 1 | Interrupt |

## Verification
A table of flag events and strobed writes covers flag setting and clearing. It separates a write of 0 from a write of 1, strobed bits from unstrobed ones, and a hardware set from a clear in the same cycle. The OUT runs feed packets shorter than a bank, packets longer than a bank and a packet while both banks are held. They also mix SETUP with data, which tells bank switching apart from flag acknowledgement and shows the clamp. The IN runs fill a bank to its limit, then kill with both banks committed and with one bank committed, and then count pushes into the killed bank. This shows that the right bank was freed and the pointers were repaired. Stall, error and control-endpoint gating are applied in the middle of a count, so an ignored push or pop shows up as a late or early drop of read/write-allowed.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  localparam int BIT_FC     = 7;
  localparam int BIT_NAKIN  = 6;
  localparam int BIT_RWAL   = 5;
  localparam int BIT_NAKOUT = 4;
  localparam int BIT_SETUP  = 3;
  localparam int BIT_RXOUT  = 2;
  localparam int BIT_STALL  = 1;
  localparam int BIT_TXIN   = 0;

  // bits that are sticky flags and may raise the interrupt
  localparam logic [7:0] FLAG_MASK = 8'h5F;

  // firmware may move data in the current bank
  function automatic logic rw_ok_calc(input logic dir_in, input logic own,
                                      input int level, input int cap,
                                      input logic blocked);
    if (blocked || !own) return 1'b0;
    return dir_in ? (level < cap) : (level != 0);
  endfunction

  function automatic int clamp_len(input int len, input int cap);
    return (len > cap) ? cap : len;
  endfunction
endpackage

// File: rtl/ep_flag_cell.sv
module ep_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  input  logic hold_clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (hold_clr) q <= 1'b0;
    else if (hw_set)   q <= 1'b1;
    else if (sw_clr)   q <= 1'b0;
  end

  a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set && !hold_clr |=> q);
  a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr && !hw_set |=> !q);
  a_r7_only_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !q && !hw_set |=> !q);
endmodule

// File: rtl/ep_bank_ctl.sv
module ep_bank_ctl
  import ep_stat_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_in,
  input  logic             blocked,
  input  logic             fill_req,
  input  logic [CNT_W-1:0] fill_len,
  input  logic             in_sent,
  input  logic             push,
  input  logic             pop,
  input  logic             release_req,
  input  logic             kill_set,
  output logic             cur_bank,
  output logic             fifo_ctl,
  output logic             rw_ok,
  output logic             fill_evt,
  output logic             free_evt,
  output logic             kill_busy
);
  logic [1:0]       own_cpu;
  logic [CNT_W-1:0] cnt [2];
  logic             cur, eng, kill_q;
  logic             other, rel_evt, push_ok, pop_ok, kill_done, kill_go;
  logic [CNT_W-1:0] len_c;

  assign other     = ~cur;
  assign len_c     = CNT_W'(clamp_len(int'(fill_len), BANK_BYTES));
  assign fifo_ctl  = own_cpu[cur];
  assign rw_ok     = rw_ok_calc(dir_in, own_cpu[cur], int'(cnt[cur]), BANK_BYTES, blocked);
  assign fill_evt  = !dir_in && fill_req && !own_cpu[eng];
  assign free_evt  = dir_in && in_sent && !own_cpu[eng];
  assign rel_evt   = release_req && own_cpu[cur];
  assign push_ok   = dir_in && push && rw_ok;
  assign pop_ok    = !dir_in && pop && rw_ok;
  assign kill_done = kill_q && !in_sent && !rel_evt;
  assign kill_go   = kill_done && dir_in && !own_cpu[other];
  assign cur_bank  = cur;
  assign kill_busy = kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_cpu <= {2{dir_in}};
      cnt[0]  <= '0;
      cnt[1]  <= '0;
      cur     <= 1'b0;
      eng     <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      if (push_ok) cnt[cur] <= cnt[cur] + 1'b1;
      if (pop_ok)  cnt[cur] <= cnt[cur] - 1'b1;
      if (fill_evt) begin
        own_cpu[eng] <= 1'b1;
        cnt[eng]     <= len_c;
        eng          <= ~eng;
      end
      if (free_evt) begin
        own_cpu[eng] <= 1'b1;
        cnt[eng]     <= '0;
        eng          <= ~eng;
      end
      if (rel_evt) begin
        own_cpu[cur] <= 1'b0;
        if (!dir_in) cnt[cur] <= '0;
        cur <= ~cur;
      end
      if (kill_go) begin
        own_cpu[other] <= 1'b1;
        cnt[other]     <= '0;
        if (!own_cpu[cur]) cur <= other;
        else               eng <= cur;
      end
      if (kill_done) kill_q <= 1'b0;
      if (kill_set)  kill_q <= 1'b1;
    end
  end

  a_r10_blocked_no_rw: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !rw_ok);
  a_r11_kill_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q && !in_sent && !rel_evt && !kill_set |=> !kill_busy);
  a_r4_release_switches: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> cur_bank != $past(cur_bank));
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in && (int'(cnt[cur]) == BANK_BYTES) |-> !rw_ok);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt[0]) <= BANK_BYTES && int'(cnt[1]) <= BANK_BYTES);
  a_r3_fill_owned: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> own_cpu[$past(eng)]);
endmodule

// File: rtl/ep_bank_status.sv
module ep_bank_status
  import ep_stat_pkg::*;
#(
  parameter int  BANK_BYTES = 64,
  localparam int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir_in,
  input  logic             cfg_ctrl_ep,
  input  logic             stall_req,
  input  logic             err_flag,
  input  logic             pe_pkt_rx,
  input  logic             pe_setup_rx,
  input  logic [CNT_W-1:0] pe_rx_len,
  input  logic             pe_in_sent,
  input  logic             pe_nak_in,
  input  logic             pe_nak_out,
  input  logic             pe_stall_sent,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wmask,
  input  logic [7:0]       reg_wdata,
  input  logic [7:0]       irq_en,
  input  logic             kill_wr,
  input  logic             kill_wdata,
  output logic [7:0]       reg_rdata,
  output logic             cur_bank,
  output logic             rw_allowed,
  output logic             kill_busy,
  output logic             irq
);
  logic [7:0] sw_clr, set_vec, hold_vec, flag_q;
  logic       blocked, fifo_ctl, fill_evt, free_evt, rel_req;

  assign blocked = stall_req | err_flag | cfg_ctrl_ep;
  assign sw_clr  = {8{reg_wr}} & reg_wmask & ~reg_wdata;
  assign rel_req = sw_clr[BIT_FC];

  ep_bank_ctl #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .dir_in(cfg_dir_in), .blocked(blocked),
    .fill_req(pe_pkt_rx | pe_setup_rx), .fill_len(pe_rx_len),
    .in_sent(pe_in_sent), .push(fifo_push), .pop(fifo_pop),
    .release_req(rel_req), .kill_set(kill_wr & kill_wdata),
    .cur_bank(cur_bank), .fifo_ctl(fifo_ctl), .rw_ok(rw_allowed),
    .fill_evt(fill_evt), .free_evt(free_evt), .kill_busy(kill_busy)
  );

  always_comb begin
    set_vec             = '0;
    hold_vec            = '0;
    set_vec[BIT_NAKIN]  = pe_nak_in;
    set_vec[BIT_NAKOUT] = pe_nak_out;
    set_vec[BIT_SETUP]  = fill_evt & pe_setup_rx;
    set_vec[BIT_RXOUT]  = fill_evt & ~pe_setup_rx;
    set_vec[BIT_STALL]  = pe_stall_sent;
    set_vec[BIT_TXIN]   = free_evt;
    hold_vec[BIT_SETUP] = cfg_dir_in;
  end

  for (genvar b = 0; b < 8; b++) begin : g_flag
    if (FLAG_MASK[b]) begin : g_cell
      ep_flag_cell u_cell (
        .clk(clk), .rst_n(rst_n), .hw_set(set_vec[b]), .sw_clr(sw_clr[b]),
        .hold_clr(hold_vec[b]), .q(flag_q[b])
      );
    end else begin : g_none
      assign flag_q[b] = 1'b0;
    end
  end

  always_comb begin
    reg_rdata           = flag_q;
    reg_rdata[BIT_FC]   = fifo_ctl;
    reg_rdata[BIT_RWAL] = rw_allowed;
  end

  assign irq = |(flag_q & irq_en & FLAG_MASK);

  a_r6_setup_held: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir_in |-> !reg_rdata[BIT_SETUP]);
  a_r4_drop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_evt && !reg_rdata[BIT_RXOUT] |=> !reg_rdata[BIT_RXOUT]);
  a_r5_txin_on_free: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |=> reg_rdata[BIT_TXIN]);
endmodule

// File: tb/ep_bank_status_tb.sv
module ep_bank_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 4;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dir_in = 0, cfg_ctrl_ep = 0, stall_req = 0, err_flag = 0;
  logic pe_pkt_rx = 0, pe_setup_rx = 0, pe_in_sent = 0;
  logic pe_nak_in = 0, pe_nak_out = 0, pe_stall_sent = 0;
  logic [CW-1:0] pe_rx_len = '0;
  logic fifo_push = 0, fifo_pop = 0, reg_wr = 0, kill_wr = 0, kill_wdata = 0;
  logic [7:0] reg_wmask = '0, reg_wdata = '0, irq_en = '0;
  logic [7:0] reg_rdata;
  logic cur_bank, rw_allowed, kill_busy, irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_bank_status #(.BANK_BYTES(BB)) u_dut (.*);

  // {nak_in,nak_out,stall_sent, wr, mask, data, irq_en, exp_rdata, exp_irq}
  localparam logic [36:0] VEC [11] = '{
    {3'b100, 1'b0, 8'h00, 8'h00, 8'h00, 8'h40, 1'b0},
    {3'b000, 1'b0, 8'h00, 8'h00, 8'h40, 8'h40, 1'b1},
    {3'b000, 1'b0, 8'h00, 8'h00, 8'hA0, 8'h40, 1'b0},
    {3'b011, 1'b0, 8'h00, 8'h00, 8'h00, 8'h52, 1'b0},
    {3'b000, 1'b1, 8'h40, 8'h00, 8'h40, 8'h12, 1'b0},
    {3'b000, 1'b1, 8'h12, 8'hFF, 8'h02, 8'h12, 1'b1},
    {3'b000, 1'b0, 8'h00, 8'h00, 8'h00, 8'h12, 1'b0},
    {3'b010, 1'b1, 8'h10, 8'h00, 8'h10, 8'h12, 1'b1},
    {3'b000, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0},
    {3'b001, 1'b0, 8'h00, 8'h00, 8'h02, 8'h02, 1'b1},
    {3'b000, 1'b1, 8'h02, 8'hFD, 8'h02, 8'h00, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dir);
    rst_n = 1'b0;
    cfg_dir_in = dir;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_reg(input logic [7:0] m, input logic [7:0] d);
    reg_wr = 1; reg_wmask = m; reg_wdata = d;
    step();
    reg_wr = 0; reg_wmask = '0; reg_wdata = '0;
  endtask

  task automatic rx(input int len, input logic setup, input logic pkt);
    pe_rx_len = CW'(len); pe_setup_rx = setup; pe_pkt_rx = pkt;
    step();
    pe_setup_rx = 0; pe_pkt_rx = 0;
  endtask

  task automatic pushes(input int n);
    for (int i = 0; i < n; i++) begin
      fifo_push = 1; step(); fifo_push = 0;
    end
  endtask

  task automatic pops(input int n);
    for (int i = 0; i < n; i++) begin
      fifo_pop = 1; step(); fifo_pop = 0;
    end
  endtask

  task automatic in_sent();
    pe_in_sent = 1; step(); pe_in_sent = 0;
  endtask

  task automatic kill(input logic v);
    kill_wr = 1; kill_wdata = v; step(); kill_wr = 0; kill_wdata = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 OUT reset state
    do_reset(1'b0);
    chk("R1 out rdata", reg_rdata, 8'h00);
    chk("R1 cur_bank", cur_bank, 0);
    chk("R1 kill_busy", kill_busy, 0);

    // R7 R8 R9 R2 flag table
    for (int i = 0; i < 11; i++) begin
      logic [36:0] v;
      v = VEC[i];
      pe_nak_in = v[36]; pe_nak_out = v[35]; pe_stall_sent = v[34];
      reg_wr = v[33]; reg_wmask = v[32:25]; reg_wdata = v[24:17]; irq_en = v[16:9];
      step();
      chk($sformatf("R8 vec%0d rdata", i), reg_rdata, v[8:1]);
      chk($sformatf("R9 vec%0d irq", i), irq, v[0]);
      pe_nak_in = 0; pe_nak_out = 0; pe_stall_sent = 0;
      reg_wr = 0; reg_wmask = '0; reg_wdata = '0;
    end
    irq_en = '0;

    // R3 OUT packet into current bank
    rx(2, 0, 1);
    chk("R3 rx sets fc rxout rwal", reg_rdata, 8'hA4);
    pops(1);
    chk("R3 one pop left", reg_rdata, 8'hA4);
    pops(1);
    chk("R3 bank empty", reg_rdata, 8'h84);
    rx(3, 0, 1);
    chk("R3 second bank fill", reg_rdata, 8'h84);
    wr_reg(8'h04, 8'h00);
    chk("R8 rxout ack", reg_rdata, 8'h80);
    // R4 drop when both banks held
    rx(1, 0, 1);
    chk("R4 dropped packet no flag", reg_rdata, 8'h80);
    wr_reg(8'h80, 8'h80);
    chk("R4 write 1 to bit7 ignored", reg_rdata, 8'h80);
    chk("R4 bank unchanged", cur_bank, 0);
    wr_reg(8'h80, 8'h00);
    chk("R4 release switches", reg_rdata, 8'hA0);
    chk("R4 cur_bank 1", cur_bank, 1);
    pops(3);
    chk("R4 bank1 had 3 bytes", reg_rdata, 8'h80);
    wr_reg(8'h80, 8'h00);
    chk("R4 both free", reg_rdata, 8'h00);
    // R6 setup wins over packet
    rx(2, 1, 1);
    chk("R6 setup precedence", reg_rdata, 8'hA8);
    irq_en = 8'h08; #1;
    chk("R9 setup irq", irq, 1);
    irq_en = 8'h04; #1;
    chk("R9 rxout not set", irq, 0);
    irq_en = 8'h00;
    // R10 stall gating
    stall_req = 1; step();
    chk("R10 stall forces rwal low", reg_rdata, 8'h88);
    pops(1);
    stall_req = 0; step();
    chk("R10 rwal back", reg_rdata, 8'hA8);
    pops(1);
    chk("R10 pop during stall ignored", reg_rdata, 8'hA8);
    pops(1);
    chk("R10 count reached zero", reg_rdata, 8'h88);
    // R3 clamp
    rx(7, 0, 1);
    chk("R3 rxout from bank1", reg_rdata, 8'h8C);
    wr_reg(8'h80, 8'h00);
    chk("R3 switch to clamped bank", reg_rdata, 8'hAC);
    pops(3);
    chk("R3 clamp 3 pops", reg_rdata, 8'hAC);
    pops(1);
    chk("R3 clamp empty at BANK_BYTES", reg_rdata, 8'h8C);
    // R11 kill on OUT endpoint
    kill(1);
    chk("R11 kill pending", kill_busy, 1);
    step();
    chk("R11 kill done on OUT", kill_busy, 0);
    chk("R11 OUT no effect", reg_rdata, 8'h8C);
    // R5 in_sent ignored on OUT
    in_sent();
    chk("R5 in_sent ignored on OUT", reg_rdata, 8'h8C);

    // R1 IN reset
    do_reset(1'b1);
    chk("R1 in rdata", reg_rdata, 8'hA0);
    rx(2, 1, 0);
    chk("R6 setup ignored on IN", reg_rdata, 8'hA0);
    // R5 fill and commit
    pushes(3);
    chk("R5 below cap", reg_rdata, 8'hA0);
    pushes(1);
    chk("R5 full", reg_rdata, 8'h80);
    wr_reg(8'h80, 8'h00);
    chk("R5 commit switch", reg_rdata, 8'hA0);
    chk("R5 cur_bank 1", cur_bank, 1);
    pushes(1);
    wr_reg(8'h80, 8'h00);
    chk("R5 both committed", reg_rdata, 8'h00);
    chk("R5 cur_bank 0", cur_bank, 0);
    // R11 kill with both committed
    kill(1);
    chk("R11 busy", kill_busy, 1);
    chk("R11 waiting rdata", reg_rdata, 8'h00);
    step();
    chk("R11 killed bank freed", reg_rdata, 8'hA0);
    chk("R11 moved to killed bank", cur_bank, 1);
    chk("R11 self clear", kill_busy, 0);
    in_sent();
    chk("R5 in_sent txin", reg_rdata, 8'hA1);
    pushes(2);
    wr_reg(8'h80, 8'h00);
    chk("R5 commit one", reg_rdata, 8'hA1);
    // R11 kill with one committed
    kill(1);
    step();
    chk("R11 one committed cur", cur_bank, 0);
    chk("R11 one committed done", kill_busy, 0);
    pushes(4);
    chk("R5 bank0 full", reg_rdata, 8'h81);
    wr_reg(8'h80, 8'h00);
    chk("R11 killed bank free", reg_rdata, 8'hA1);
    chk("R11 cur 1", cur_bank, 1);
    in_sent();
    pushes(3);
    chk("R11 killed count zero 3", reg_rdata, 8'hA1);
    pushes(1);
    chk("R11 killed count zero 4", reg_rdata, 8'h81);
    // R11 kill deferred by in_sent
    kill(1);
    pe_in_sent = 1; step(); pe_in_sent = 0;
    chk("R11 deferred by in_sent", kill_busy, 1);
    step();
    chk("R11 deferred then done", kill_busy, 0);
    chk("R11 no committed no effect", reg_rdata, 8'h81);
    // R10 error and control endpoint gating
    wr_reg(8'h80, 8'h00);
    chk("R10 fresh bank", reg_rdata, 8'hA1);
    err_flag = 1; step();
    chk("R10 err forces low", reg_rdata, 8'h81);
    pushes(1);
    err_flag = 0;
    pushes(3);
    chk("R10 push during err ignored", reg_rdata, 8'hA1);
    cfg_ctrl_ep = 1; step();
    chk("R10 ctrl ep forces low", reg_rdata, 8'h81);
    cfg_ctrl_ep = 0;
    pushes(1);
    chk("R10 full after 4", reg_rdata, 8'h81);
    kill(0);
    chk("R11 write 0 ignored", kill_busy, 0);

    finish_run();
  end
endmodule